// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block holds a 64-bit free-running time counter and a 64-bit compare value. Software reaches both through ordinary loads and stores on a word-addressed bus. Each value is split into two 32-bit words, so the block occupies four consecutive word locations starting at a configurable base address.

The block drives a timer interrupt-pending level to the trap logic. That level is high whenever the counter has reached the compare value. Software cannot clear it by writing a flag. It clears only when the compare value or the counter is rewritten so that the condition no longer holds.

The full counter value is also brought out on a dedicated port. The read-only user time CSRs read from that port at any privilege level, with no counter-enable check. Software is expected to update a 64-bit value as two ordered word writes, low word first and high word second.

Top module: `mach_timer`

## Requirements
- R1: After reset, all four words read 0, `time_o` is 0, `rdata_o` is 0, and `irq_pend_o` is 1, because 0 >= 0.
- R2: The counter increments by one on every clock edge where `tick_en_i` is 1 and the counter is not written in that cycle. It holds its value while `tick_en_i` is 0.
- R3: The word address `BASE_ADDR + k` selects one word. k=0 is the counter low word, k=1 the counter high word, k=2 the compare low word and k=3 the compare high word. A read request returns the addressed word on `rdata_o` in the following cycle.
- R4: A write to one counter word replaces only that word. No increment is applied in the write cycle. Counting resumes from the written value on the next enabled tick.
- R5: Both compare words are writable and read back the written value. The compare value does not change unless it is written.
- R6: `irq_pend_o` equals the unsigned 64-bit comparison counter >= compare. It reflects a write or a tick from the clock edge that applies it, including the equality boundary.
- R7: With no counter or compare write, and no counter wrap, `irq_pend_o` never falls once it is high.
- R8: A request outside the four-word window writes nothing, and its read returns 0. When `req_i` is 0, `we_i` and `addr_i` have no effect.
- R9: `time_o` carries the live 64-bit counter at all times. It matches the two counter words read over the bus.
- R10: Counting carries from the low word into the high word (0x0000_0000_FFFF_FFFF + 1 = 0x0000_0001_0000_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Count enable for the time counter |
| req_i | input | 1 | Bus request valid for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (32) | Word address |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, one cycle after a read request, else 0 |
| irq_pend_o | output | 1 | Timer interrupt-pending level |
| time_o | output | TW (64) | Live counter value for the user time CSRs |

## Verification
A wrong counter or compare word appears on `time_o` or `irq_pend_o` at the first falling edge after the clock edge that stored it. A corrupted word becomes visible on `rdata_o` one cycle after a read. The bench writes and reads each word, then crosses the equality boundary of the comparison both by counting and by rewriting single words. A wrong half-write or a dropped carry therefore shows as a mismatched 64-bit value within a handful of cycles. Out-of-window and idle-bus stimulus is followed by reads of the words it could have corrupted.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TIME_W = 64;
  // first word of the IO region (word address)
  localparam logic [ADDR_W-1:0] IO_REGION_BASE = 32'h4000_0000;
endpackage

// File: rtl/mt_decode.sv
module mt_decode #(
  parameter int unsigned AW = 32,
  parameter int unsigned NW = 4,
  parameter logic [AW-1:0] BASE = '0,
  localparam int unsigned OFF_W = $clog2(NW)
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  output logic [NW-1:0]    wr_sel_o,
  output logic             rd_en_o,
  output logic [OFF_W-1:0] rd_idx_o
);
  logic hit;

  // BASE must be aligned to NW words
  assign hit      = req_i && (addr_i[AW-1:OFF_W] == BASE[AW-1:OFF_W]);
  assign rd_en_o  = hit && !we_i;
  assign rd_idx_o = addr_i[OFF_W-1:0];

  for (genvar i = 0; i < NW; i++) begin : g_sel
    assign wr_sel_o[i] = hit && we_i && (addr_i[OFF_W-1:0] == OFF_W'(i));
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned TW = 64,
  parameter int unsigned DW = 32,
  localparam int unsigned CW = TW / DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] wr_sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          wr_any;

  assign wr_any = |wr_sel_i;

  // bus write wins over tick; untouched words hold
  always_comb begin
    cnt_d = cnt_q;
    if (wr_any) begin
      for (int w = 0; w < CW; w++) begin
        if (wr_sel_i[w]) cnt_d[w*DW +: DW] = wdata_i;
      end
    end else if (tick_i) begin
      cnt_d = cnt_q + {{(TW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_any) |=> (cnt_q == $past(cnt_q) + {{(TW-1){1'b0}}, 1'b1}));
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_any) |=> $stable(cnt_q));
  a_r4_low_word_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i == CW'(1)) |=> (cnt_q[DW-1:0] == $past(wdata_i)) &&
                             (cnt_q[TW-1:DW] == $past(cnt_q[TW-1:DW])));
endmodule

// File: rtl/mt_compare.sv
module mt_compare #(
  parameter int unsigned TW = 64,
  parameter int unsigned DW = 32,
  localparam int unsigned CW = TW / DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wr_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] time_i,
  output logic [TW-1:0] cmp_o,
  output logic          pend_o
);
  logic [TW-1:0] cmp_q;

  for (genvar w = 0; w < CW; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmp_q[w*DW +: DW] <= '0;
      else if (wr_sel_i[w]) cmp_q[w*DW +: DW] <= wdata_i;
    end
  end

  assign cmp_o  = cmp_q;
  assign pend_o = (time_i >= cmp_q);

  a_r5_cmp_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wr_sel_i) |=> $stable(cmp_q));
endmodule

// File: rtl/mt_readback.sv
module mt_readback #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 4,
  localparam int unsigned OFF_W = $clog2(NW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW*DW-1:0] words_i,
  input  logic             rd_en_i,
  input  logic [OFF_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= words_i[rd_idx_i*DW +: DW];
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  a_r8_no_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));
endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned TW = TIME_W,
  parameter logic [AW-1:0] BASE_ADDR = IO_REGION_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_pend_o,
  output logic [TW-1:0] time_o
);
  localparam int unsigned CW    = TW / DW;
  localparam int unsigned NW    = 2 * CW;
  localparam int unsigned OFF_W = $clog2(NW);

  logic [NW-1:0]    wr_sel;
  logic             rd_en;
  logic [OFF_W-1:0] rd_idx;
  logic [TW-1:0]    cnt, cmp;

  mt_decode #(.AW(AW), .NW(NW), .BASE(BASE_ADDR)) u_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .rd_en_o  (rd_en),
    .rd_idx_o (rd_idx)
  );

  mt_counter #(.TW(TW), .DW(DW)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_en_i),
    .wr_sel_i (wr_sel[CW-1:0]),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt)
  );

  mt_compare #(.TW(TW), .DW(DW)) u_compare (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel[NW-1:CW]),
    .wdata_i  (wdata_i),
    .time_i   (cnt),
    .cmp_o    (cmp),
    .pend_o   (irq_pend_o)
  );

  mt_readback #(.DW(DW), .NW(NW)) u_readback (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .words_i  ({cmp, cnt}),
    .rd_en_i  (rd_en),
    .rd_idx_i (rd_idx),
    .rdata_o  (rdata_o)
  );

  assign time_o = cnt;

  // pending only falls through a rewrite or a counter wrap
  a_r7_no_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_o && !(|wr_sel) && !(&cnt)) |=> irq_pend_o);
  a_r8_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i[AW-1:OFF_W] != BASE_ADDR[AW-1:OFF_W]))
      |=> ($stable(cnt) || $past(tick_en_i)) && $stable(cmp));
endmodule

// File: tb/mach_timer_tb_top.sv
module mach_timer_tb_top;
  import mach_timer_pkg::*;

  localparam logic [31:0] B = IO_REGION_BASE;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, B+2, 32'h0000_0010, 32'h0, 4'd5},   // R5 cmp lo
    '{OP_PD, B,   32'h0,         32'h0, 4'd6},   // R6 0 < 0x10
    '{OP_WR, B+0, 32'h0000_0020, 32'h0, 4'd4},   // R4 time lo
    '{OP_PD, B,   32'h0,         32'h1, 4'd6},   // R6
    '{OP_RD, B+0, 32'h0,         32'h0000_0020, 4'd3}, // R3
    '{OP_RD, B+2, 32'h0,         32'h0000_0010, 4'd5}, // R5
    '{OP_WR, B+3, 32'h0000_0001, 32'h0, 4'd7},   // R7 clear by cmp rewrite
    '{OP_PD, B,   32'h0,         32'h0, 4'd7},
    '{OP_RD, B+3, 32'h0,         32'h1, 4'd3},
    '{OP_WR, B+1, 32'h0000_0001, 32'h0, 4'd4},   // R4 time hi
    '{OP_PD, B,   32'h0,         32'h1, 4'd6},
    '{OP_RD, B+1, 32'h0,         32'h1, 4'd3},
    '{OP_WR, B+4, 32'hDEAD_BEEF, 32'h0, 4'd8},   // R8 miss write
    '{OP_RD, B+4, 32'h0,         32'h0, 4'd8},   // R8 miss read
    '{OP_RD, B-1, 32'h0,         32'h0, 4'd8},
    '{OP_RD, B+0, 32'h0,         32'h0000_0020, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pend;
  logic [63:0] tval;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mach_timer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_en_i  (tick_en),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_pend_o (pend),
    .time_o     (tval)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 time_o", tval, 64'h0);
    chk("R1 rdata", {32'h0, rdata}, 64'h0);
    chk("R1 pend", {63'h0, pend}, 64'h1);
    for (int k = 0; k < 4; k++) begin
      bus_rd(B + k, rd);
      chk("R1 word", {32'h0, rd}, 64'h0);
    end

    // table walk, tick disabled
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR: bus_wr(VECS[i].addr, VECS[i].data);
        OP_RD: begin
          bus_rd(VECS[i].addr, rd);
          chk(tg, {32'h0, rd}, {32'h0, VECS[i].exp});
        end
        default: chk(tg, {63'h0, pend}, {32'h0, VECS[i].exp});
      endcase
    end

    // R8 idle bus: we/addr without req
    @(negedge clk);
    req = 1'b0; we = 1'b1; addr = B; wdata = 32'h1234_5678;
    @(negedge clk);
    we = 1'b0;
    bus_rd(B, rd);
    chk("R8 idle write ignored", {32'h0, rd}, 64'h20);

    // R9 live time matches bus words
    chk("R9 time_o", tval, 64'h1_0000_0020);

    // R2 count and hold
    bus_wr(B + 1, 32'h0);
    bus_wr(B + 0, 32'h0);
    @(negedge clk); tick_en = 1'b1;
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    chk("R2 ten ticks", tval, 64'd10);
    repeat (5) @(negedge clk);
    chk("R2 hold", tval, 64'd10);

    // R6 equality boundary reached by counting
    bus_wr(B + 3, 32'h0);
    bus_wr(B + 2, 32'd50);
    bus_wr(B + 0, 32'd40);
    chk("R6 below", {63'h0, pend}, 64'h0);
    tick_en = 1'b1;
    repeat (9) @(negedge clk);
    tick_en = 1'b0;
    chk("R6 49<50", {63'h0, pend}, 64'h0);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk("R6 50>=50", {63'h0, pend}, 64'h1);

    // R10 carry
    bus_wr(B + 0, 32'hFFFF_FFFE);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    chk("R10 carry", tval, 64'h1_0000_0001);
    bus_rd(B + 1, rd);
    chk("R10 hi word", {32'h0, rd}, 64'h1);

    // R4 write while counting
    bus_wr(B + 1, 32'h0);
    tick_en = 1'b1;
    bus_wr(B + 0, 32'h100);
    chk("R4 write cycle no inc", tval, 64'h100);
    @(negedge clk);
    chk("R4 resume", tval, 64'h101);
    tick_en = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule